// File: doc/BRIEF.md
# Instruction Stream Hazard Checker

This block sits beside a processor's issue stage and watches the scheduled instruction stream, one pre-decoded instruction per valid cycle. It checks the stream against the scheduling rules that the hardware does not enforce itself:

- delay-slot windows after branches and thread switches;
- the latency window of the special-function unit;
- the limit of one shared-resource access per instruction;
- adjacency rules for uniform and varying loads;
- the thread-switch sequence that marks and ends the final program segment.

The first rule that an instruction breaks is latched as a sticky error. The error carries a reason code and the index of the offending instruction, and it holds until reset.

Each instruction is presented as flags:

- whether it is a branch or an ALU instruction;
- for each of the two ALU slots (add and multiply), whether the slot is active, whether it writes a special target, and which target class it writes;
- the load and signal bits;
- whether it reads or writes the special-function result register.

Positions of the latest branch, thread switch and special-function start are kept as signed 16-bit indices. Every window test is a difference between the current index and one of these positions. A strobe at the end of the program runs the completion checks. A configuration input selects single-segment mode.

Top module: `isched_hazard_mon`

## Requirements
- R1: After reset, `err_flag`, `err_code`, `err_idx` and `eop_done` are 0. The stored positions start at index -10, so no window is open for the first instructions.
- R2: Index distance is the current index minus a stored position. These instructions are errors:
  - a branch at distance 1 or 2 from the previous branch (code 14);
  - a branch at distance 1 or 2 from the previous thread switch (code 15);
  - a thread switch at distance 1 or 2 from the previous branch (code 9);
  - a thread switch at distance 2 from the previous switch (code 11).
  Distance 3 opens no window.
- R3: The result register may not be touched in the instruction right after a special-function start. A special-function start is an active slot with the special bit set and target 2. In that next instruction, reading the result register is code 5, writing it is code 6, and starting another special-function operation is code 7.
- R4: Inside a thread-switch window (distance 1 or 2), a special-function start is code 3 and a varying load is code 4.
- R5: An instruction may do at most one shared-resource access. The accesses counted are special writes to targets 1 to 5 (texture 1, special-function 2, vertex memory 3, tile buffer 4, sync 5) and the texture, tile, tile-uniform and vertex-memory loads. Two or more in one instruction is code 8.
- R6: A plain or address uniform load directly after a varying load is code 1. A plain uniform load (either form) next to an address uniform load (either form), in either order, is code 2.
- R7: A thread switch at distance exactly 1 from the previous switch is a last-segment marker. It does not count as a switch. A marker seen when one was already seen is code 10.
- R8: A thread switch seen once a marker exists sets the program-end state. From that instruction on, any register-file write is code 12. A register-file write is an active slot without the special bit, or a load-signal write without its special bit. A texture wait at distance 2 from the last switch is code 13.
- R9: `eop` runs the completion checks at index = instruction count. More than one switch with no marker is code 16. Otherwise, no program-end switch is code 17. `eop_done` rises one cycle after `eop`.
- R10: With `cfg_single_seg` high during reset, the marker counts as already seen. The first switch then ends the program.
- R11: The error is sticky. The first violation's code and index appear one cycle after the instruction and hold until reset.
- R12: When an instruction breaks several rules, the lowest code number is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_single_seg | input | 1 | Single-segment mode, sampled during reset |
| ins_vld | input | 1 | An instruction is presented this cycle |
| ins_is_br | input | 1 | Instruction is a branch (ALU fields ignored) |
| add_act | input | 1 | Add slot carries an operation |
| add_spc | input | 1 | Add slot writes a special target |
| add_tgt | input | 3 | Add slot special target class |
| add_twait | input | 1 | Add slot operation is a texture wait |
| mul_act | input | 1 | Multiply slot carries an operation |
| mul_spc | input | 1 | Multiply slot writes a special target |
| mul_tgt | input | 3 | Multiply slot special target class |
| ld_var | input | 1 | Varying load |
| ld_uni | input | 1 | Plain uniform load |
| ld_uni_rf | input | 1 | Plain uniform load into register file |
| ld_unia | input | 1 | Address uniform load |
| ld_unia_rf | input | 1 | Address uniform load into register file |
| ld_tex | input | 1 | Texture load |
| ld_tile | input | 1 | Tile-buffer load |
| ld_tileu | input | 1 | Tile-buffer uniform load |
| ld_vmem | input | 1 | Vertex-memory load |
| sig_wr | input | 1 | Load signal writes a destination |
| sig_spc | input | 1 | That destination is special |
| thr_sw | input | 1 | Thread switch signal |
| rd_res | input | 1 | Reads the special-function result register |
| wr_res | input | 1 | Writes the special-function result register |
| eop | input | 1 | End-of-program strobe |
| err_flag | output | 1 | Sticky violation flag |
| err_code | output | 5 | Reason code of the first violation |
| err_idx | output | 16 | Index of the first violation |
| eop_done | output | 1 | Completion checks have run |

## Verification
The assertions assume three things about the inputs:

- `eop` never shares a cycle with `ins_vld`;
- a program is far shorter than the index range, so the signed distances never wrap;
- the adjacency properties treat two valid instructions in consecutive cycles as consecutive indices.

The bench keeps to these rules. It drops `eop` only on idle cycles and limits programs to at most 15 instructions. It leaves `ins_vld` high from one instruction to the next, so the adjacency checks see back-to-back indices.

// File: rtl/isched_pkg.sv
package isched_pkg;

  typedef enum logic [4:0] {
    V_NONE          = 5'd0,
    V_UNI_AFTER_VAR = 5'd1,
    V_UNI_MIX       = 5'd2,
    V_SFU_IN_SW     = 5'd3,
    V_VAR_IN_SW     = 5'd4,
    V_RES_RD        = 5'd5,
    V_RES_WR        = 5'd6,
    V_SFU_GAP       = 5'd7,
    V_MULTI_RES     = 5'd8,
    V_SW_IN_BR      = 5'd9,
    V_TWO_MARKERS   = 5'd10,
    V_SW_CLOSE      = 5'd11,
    V_RF_AFTER_END  = 5'd12,
    V_TWAIT_LAST    = 5'd13,
    V_BR_IN_BR      = 5'd14,
    V_BR_IN_SW      = 5'd15,
    V_NO_MARKER     = 5'd16,
    V_NO_END        = 5'd17
  } viol_e;

  typedef enum logic [2:0] {
    T_OTHER = 3'd0,
    T_TEX   = 3'd1,
    T_SFU   = 3'd2,
    T_VMEM  = 3'd3,
    T_TILE  = 3'd4,
    T_SYNC  = 3'd5
  } tgt_e;

  typedef struct packed {
    logic       br;
    logic       add_act;
    logic       add_spc;
    logic [2:0] add_tgt;
    logic       add_twait;
    logic       mul_act;
    logic       mul_spc;
    logic [2:0] mul_tgt;
    logic       ld_var;
    logic       ld_uni;
    logic       ld_uni_rf;
    logic       ld_unia;
    logic       ld_unia_rf;
    logic       ld_tex;
    logic       ld_tile;
    logic       ld_tileu;
    logic       ld_vmem;
    logic       sig_wr;
    logic       sig_spc;
    logic       thr_sw;
    logic       rd_res;
    logic       wr_res;
  } ins_t;

endpackage

// File: rtl/isched_slot_dec.sv
module isched_slot_dec
  import isched_pkg::*;
(
  input  logic       act,
  input  logic       spc,
  input  logic [2:0] tgt,
  output logic       res_hit,
  output logic       sfu_hit,
  output logic       rf_hit
);
  // A slot only counts when it carries an operation.
  logic spc_wr;
  assign spc_wr  = act && spc;
  assign res_hit = spc_wr && (tgt == T_TEX  || tgt == T_SFU || tgt == T_VMEM ||
                              tgt == T_TILE || tgt == T_SYNC);
  assign sfu_hit = spc_wr && (tgt == T_SFU);
  assign rf_hit  = act && !spc;
endmodule

// File: rtl/isched_track.sv
module isched_track
  import isched_pkg::*;
#(
  parameter int IDX_W     = 16,
  parameter int RESET_POS = -10,
  parameter int CNT_W     = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_single,
  input  logic                    step,
  input  logic                    upd_br,
  input  logic                    upd_sw,
  input  logic                    upd_mark,
  input  logic                    upd_end,
  input  logic                    upd_sfu,
  input  logic                    nxt_uni,
  input  logic                    nxt_unia,
  input  logic                    nxt_var,
  output logic signed [IDX_W-1:0] ip,
  output logic signed [IDX_W-1:0] pos_br,
  output logic signed [IDX_W-1:0] pos_sw,
  output logic signed [IDX_W-1:0] pos_sfu,
  output logic                    mark_seen,
  output logic                    end_seen,
  output logic                    multi_sw,
  output logic                    prv_uni,
  output logic                    prv_unia,
  output logic                    prv_var
);
  localparam logic signed [IDX_W-1:0] POS0 = IDX_W'(RESET_POS);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] sw_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ip        <= '0;
      pos_br    <= POS0;
      pos_sw    <= POS0;
      pos_sfu   <= POS0;
      mark_seen <= cfg_single;
      end_seen  <= 1'b0;
      sw_cnt    <= '0;
      prv_uni   <= 1'b0;
      prv_unia  <= 1'b0;
      prv_var   <= 1'b0;
    end else if (step) begin
      ip       <= ip + 1'b1;
      prv_uni  <= nxt_uni;
      prv_unia <= nxt_unia;
      prv_var  <= nxt_var;
      if (upd_br)   pos_br    <= ip;
      if (upd_sfu)  pos_sfu   <= ip;
      if (upd_mark) mark_seen <= 1'b1;
      if (upd_end)  end_seen  <= 1'b1;
      if (upd_sw) begin
        pos_sw <= ip;
        if (sw_cnt != CNT_MAX) sw_cnt <= sw_cnt + 1'b1;
      end
    end
  end

  assign multi_sw = sw_cnt > CNT_W'(1);
endmodule

// File: rtl/isched_rules.sv
module isched_rules
  import isched_pkg::*;
#(
  parameter int IDX_W    = 16,
  parameter int SLOT_WIN = 3,
  parameter int SFU_LAT  = 2
) (
  input  ins_t                    ins,
  input  logic signed [IDX_W-1:0] ip,
  input  logic signed [IDX_W-1:0] pos_br,
  input  logic signed [IDX_W-1:0] pos_sw,
  input  logic signed [IDX_W-1:0] pos_sfu,
  input  logic                    mark_seen,
  input  logic                    end_seen,
  input  logic                    multi_sw,
  input  logic                    prv_uni,
  input  logic                    prv_unia,
  input  logic                    prv_var,
  output viol_e                   code,
  output viol_e                   end_code,
  output logic                    upd_br,
  output logic                    upd_sw,
  output logic                    upd_mark,
  output logic                    upd_end,
  output logic                    upd_sfu,
  output logic                    nxt_uni,
  output logic                    nxt_unia,
  output logic                    nxt_var
);
  localparam int NSLOT = 2;
  localparam logic signed [IDX_W-1:0] WIN  = IDX_W'(SLOT_WIN);
  localparam logic signed [IDX_W-1:0] LAT  = IDX_W'(SFU_LAT);
  localparam logic signed [IDX_W-1:0] ONE  = IDX_W'(1);
  localparam logic signed [IDX_W-1:0] LAST = IDX_W'(SLOT_WIN - 1);

  // Slot decode, one decoder per ALU slot
  logic [NSLOT-1:0] s_act, s_spc, s_res, s_sfu, s_rf;
  logic [2:0]       s_tgt [NSLOT];

  assign s_act    = {ins.mul_act, ins.add_act};
  assign s_spc    = {ins.mul_spc, ins.add_spc};
  assign s_tgt[0] = ins.add_tgt;
  assign s_tgt[1] = ins.mul_tgt;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    isched_slot_dec u_dec (
      .act     (s_act[g]),
      .spc     (s_spc[g]),
      .tgt     (s_tgt[g]),
      .res_hit (s_res[g]),
      .sfu_hit (s_sfu[g]),
      .rf_hit  (s_rf[g])
    );
  end

  // Distances to stored positions
  logic signed [IDX_W-1:0] d_br, d_sw, d_sfu, d_sw_post;
  logic in_br, in_sw, in_sfu;
  assign d_br   = ip - pos_br;
  assign d_sw   = ip - pos_sw;
  assign d_sfu  = ip - pos_sfu;
  assign in_br  = d_br < WIN;
  assign in_sw  = d_sw < WIN;
  assign in_sfu = d_sfu < LAT;

  // Per-instruction conditions
  logic alu, sw, marker, sfu_start, multi_res, rf_wr, end_now, uni_any, unia_any;
  assign alu       = !ins.br;
  assign sw        = alu && ins.thr_sw;
  assign marker    = sw && (d_sw == ONE);
  assign sfu_start = alu && (|s_sfu);
  assign multi_res = $countones({s_res, ins.ld_tex, ins.ld_tile, ins.ld_tileu, ins.ld_vmem}) > 1;
  assign rf_wr     = (|s_rf) || (ins.sig_wr && !ins.sig_spc);
  assign end_now   = end_seen || (sw && mark_seen);
  assign d_sw_post = (sw && !marker) ? '0 : d_sw;
  assign uni_any   = ins.ld_uni || ins.ld_uni_rf;
  assign unia_any  = ins.ld_unia || ins.ld_unia_rf;

  always_comb begin
    code = V_NONE;
    if (ins.br) begin
      if (in_br)      code = V_BR_IN_BR;
      else if (in_sw) code = V_BR_IN_SW;
    end else begin
      if (prv_var && (ins.ld_uni || ins.ld_unia))           code = V_UNI_AFTER_VAR;
      else if ((prv_uni && unia_any) || (prv_unia && uni_any)) code = V_UNI_MIX;
      else if (in_sw && sfu_start)                          code = V_SFU_IN_SW;
      else if (in_sw && ins.ld_var)                         code = V_VAR_IN_SW;
      else if (in_sfu && ins.rd_res)                        code = V_RES_RD;
      else if (in_sfu && ins.wr_res)                        code = V_RES_WR;
      else if (in_sfu && sfu_start)                         code = V_SFU_GAP;
      else if (multi_res)                                   code = V_MULTI_RES;
      else if (sw && in_br)                                 code = V_SW_IN_BR;
      else if (marker && mark_seen)                         code = V_TWO_MARKERS;
      else if (sw && !marker && in_sw)                      code = V_SW_CLOSE;
      else if (end_now && rf_wr)                            code = V_RF_AFTER_END;
      else if (end_now && ins.add_twait && d_sw_post == LAST) code = V_TWAIT_LAST;
    end
  end

  always_comb begin
    if (multi_sw && !mark_seen) end_code = V_NO_MARKER;
    else if (!end_seen)         end_code = V_NO_END;
    else                        end_code = V_NONE;
  end

  assign upd_br   = ins.br;
  assign upd_sw   = sw && !marker;
  assign upd_mark = marker;
  assign upd_end  = sw && mark_seen;
  assign upd_sfu  = sfu_start;
  assign nxt_uni  = alu && uni_any;
  assign nxt_unia = alu && unia_any;
  assign nxt_var  = alu && ins.ld_var;
endmodule

// File: rtl/isched_err_latch.sv
module isched_err_latch
  import isched_pkg::*;
#(
  parameter int IDX_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  viol_e            cand_code,
  input  logic [IDX_W-1:0] cand_idx,
  output logic             flag,
  output logic [4:0]       code,
  output logic [IDX_W-1:0] idx
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      code <= '0;
      idx  <= '0;
    end else if (!flag && cand_code != V_NONE) begin
      flag <= 1'b1;
      code <= cand_code;
      idx  <= cand_idx;
    end
  end
endmodule

// File: rtl/isched_hazard_mon.sv
module isched_hazard_mon
  import isched_pkg::*;
#(
  parameter int IDX_W     = 16,
  parameter int SLOT_WIN  = 3,
  parameter int SFU_LAT   = 2,
  parameter int RESET_POS = -10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_single_seg,
  input  logic             ins_vld,
  input  logic             ins_is_br,
  input  logic             add_act,
  input  logic             add_spc,
  input  logic [2:0]       add_tgt,
  input  logic             add_twait,
  input  logic             mul_act,
  input  logic             mul_spc,
  input  logic [2:0]       mul_tgt,
  input  logic             ld_var,
  input  logic             ld_uni,
  input  logic             ld_uni_rf,
  input  logic             ld_unia,
  input  logic             ld_unia_rf,
  input  logic             ld_tex,
  input  logic             ld_tile,
  input  logic             ld_tileu,
  input  logic             ld_vmem,
  input  logic             sig_wr,
  input  logic             sig_spc,
  input  logic             thr_sw,
  input  logic             rd_res,
  input  logic             wr_res,
  input  logic             eop,
  output logic             err_flag,
  output logic [4:0]       err_code,
  output logic [IDX_W-1:0] err_idx,
  output logic             eop_done
);
  ins_t ins;
  assign ins = '{br: ins_is_br, add_act: add_act, add_spc: add_spc, add_tgt: add_tgt,
                 add_twait: add_twait, mul_act: mul_act, mul_spc: mul_spc, mul_tgt: mul_tgt,
                 ld_var: ld_var, ld_uni: ld_uni, ld_uni_rf: ld_uni_rf, ld_unia: ld_unia,
                 ld_unia_rf: ld_unia_rf, ld_tex: ld_tex, ld_tile: ld_tile, ld_tileu: ld_tileu,
                 ld_vmem: ld_vmem, sig_wr: sig_wr, sig_spc: sig_spc, thr_sw: thr_sw,
                 rd_res: rd_res, wr_res: wr_res};

  logic signed [IDX_W-1:0] ip, pos_br, pos_sw, pos_sfu;
  logic mark_seen, end_seen, multi_sw, prv_uni, prv_unia, prv_var;
  logic upd_br, upd_sw, upd_mark, upd_end, upd_sfu, nxt_uni, nxt_unia, nxt_var;
  viol_e step_code, end_code, cand_code;

  isched_track #(.IDX_W(IDX_W), .RESET_POS(RESET_POS)) u_track (
    .clk(clk), .rst(rst), .cfg_single(cfg_single_seg), .step(ins_vld),
    .upd_br(upd_br), .upd_sw(upd_sw), .upd_mark(upd_mark), .upd_end(upd_end),
    .upd_sfu(upd_sfu), .nxt_uni(nxt_uni), .nxt_unia(nxt_unia), .nxt_var(nxt_var),
    .ip(ip), .pos_br(pos_br), .pos_sw(pos_sw), .pos_sfu(pos_sfu),
    .mark_seen(mark_seen), .end_seen(end_seen), .multi_sw(multi_sw),
    .prv_uni(prv_uni), .prv_unia(prv_unia), .prv_var(prv_var)
  );

  isched_rules #(.IDX_W(IDX_W), .SLOT_WIN(SLOT_WIN), .SFU_LAT(SFU_LAT)) u_rules (
    .ins(ins), .ip(ip), .pos_br(pos_br), .pos_sw(pos_sw), .pos_sfu(pos_sfu),
    .mark_seen(mark_seen), .end_seen(end_seen), .multi_sw(multi_sw),
    .prv_uni(prv_uni), .prv_unia(prv_unia), .prv_var(prv_var),
    .code(step_code), .end_code(end_code),
    .upd_br(upd_br), .upd_sw(upd_sw), .upd_mark(upd_mark), .upd_end(upd_end),
    .upd_sfu(upd_sfu), .nxt_uni(nxt_uni), .nxt_unia(nxt_unia), .nxt_var(nxt_var)
  );

  always_comb begin
    if (ins_vld)  cand_code = step_code;
    else if (eop) cand_code = end_code;
    else          cand_code = V_NONE;
  end

  isched_err_latch #(.IDX_W(IDX_W)) u_latch (
    .clk(clk), .rst(rst), .cand_code(cand_code), .cand_idx($unsigned(ip)),
    .flag(err_flag), .code(err_code), .idx(err_idx)
  );

  always_ff @(posedge clk) begin
    if (rst)      eop_done <= 1'b0;
    else if (eop) eop_done <= 1'b1;
  end
endmodule

// File: rtl/isched_hazard_mon_chk.sv
module isched_hazard_mon_chk #(
  parameter int IDX_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             ins_vld,
  input logic             ins_is_br,
  input logic             add_act,
  input logic             add_spc,
  input logic [2:0]       add_tgt,
  input logic             mul_act,
  input logic             mul_spc,
  input logic [2:0]       mul_tgt,
  input logic             ld_var,
  input logic             ld_uni,
  input logic             rd_res,
  input logic             eop,
  input logic             err_flag,
  input logic [4:0]       err_code,
  input logic [IDX_W-1:0] err_idx,
  input logic             eop_done
);
  logic alu_v, sfu_go;
  assign alu_v  = ins_vld && !ins_is_br;
  assign sfu_go = alu_v && ((add_act && add_spc && add_tgt == 3'd2) ||
                            (mul_act && mul_spc && mul_tgt == 3'd2));

  // R1: reset clears the error outputs
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!err_flag && err_code == 5'd0 && err_idx == '0 && !eop_done));

  // R11: latched error stays put
  assert_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> (err_flag && $stable(err_code) && $stable(err_idx)));

  // R11: no code without the flag
  assert_code_flag_R11: assert property (@(posedge clk) disable iff (rst)
    !err_flag |-> err_code == 5'd0);

  // R2: back-to-back branches
  assert_br_gap_R2: assert property (@(posedge clk) disable iff (rst)
    (ins_vld && ins_is_br) ##1 (ins_vld && ins_is_br) |=> err_flag);

  // R3: result read right after special-function start
  assert_sfu_read_R3: assert property (@(posedge clk) disable iff (rst)
    sfu_go ##1 (alu_v && rd_res) |=> err_flag);

  // R6: uniform load right after a varying load
  assert_uni_var_R6: assert property (@(posedge clk) disable iff (rst)
    (alu_v && ld_var) ##1 (alu_v && ld_uni) |=> err_flag);

  // R9: completion strobe is acknowledged
  assert_eop_done_R9: assert property (@(posedge clk) disable iff (rst)
    eop |=> eop_done);

  // R9: input rule, strobe only on idle cycles
  assert_eop_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !(eop && ins_vld));
endmodule

bind isched_hazard_mon isched_hazard_mon_chk #(.IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst(rst), .ins_vld(ins_vld), .ins_is_br(ins_is_br),
  .add_act(add_act), .add_spc(add_spc), .add_tgt(add_tgt),
  .mul_act(mul_act), .mul_spc(mul_spc), .mul_tgt(mul_tgt),
  .ld_var(ld_var), .ld_uni(ld_uni), .rd_res(rd_res), .eop(eop),
  .err_flag(err_flag), .err_code(err_code), .err_idx(err_idx), .eop_done(eop_done)
);

// File: tb/isched_hazard_mon_tb.sv
`timescale 1ns/1ps
module isched_hazard_mon_tb_top;
  import isched_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg = 1'b0;
  logic vld = 1'b0;
  logic eop = 1'b0;
  ins_t cur = '0;
  logic        err_flag, eop_done;
  logic [4:0]  err_code;
  logic [15:0] err_idx;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 0;

  always #2.5 clk = ~clk;

  isched_hazard_mon dut_i (
    .clk(clk), .rst(rst), .cfg_single_seg(cfg), .ins_vld(vld), .ins_is_br(cur.br),
    .add_act(cur.add_act), .add_spc(cur.add_spc), .add_tgt(cur.add_tgt),
    .add_twait(cur.add_twait), .mul_act(cur.mul_act), .mul_spc(cur.mul_spc),
    .mul_tgt(cur.mul_tgt), .ld_var(cur.ld_var), .ld_uni(cur.ld_uni),
    .ld_uni_rf(cur.ld_uni_rf), .ld_unia(cur.ld_unia), .ld_unia_rf(cur.ld_unia_rf),
    .ld_tex(cur.ld_tex), .ld_tile(cur.ld_tile), .ld_tileu(cur.ld_tileu),
    .ld_vmem(cur.ld_vmem), .sig_wr(cur.sig_wr), .sig_spc(cur.sig_spc),
    .thr_sw(cur.thr_sw), .rd_res(cur.rd_res), .wr_res(cur.wr_res), .eop(eop),
    .err_flag(err_flag), .err_code(err_code), .err_idx(err_idx), .eop_done(eop_done)
  );

  // Reference model state, built from the requirements
  int m_ip, m_br, m_sw, m_sfu, m_swc;
  bit m_mark, m_end, p_uni, p_unia, p_var;
  bit e_flag;
  int e_code, e_idx;

  task automatic model_reset(input bit single);
    m_ip = 0; m_br = -10; m_sw = -10; m_sfu = -10; m_swc = 0;
    m_mark = single; m_end = 0; p_uni = 0; p_unia = 0; p_var = 0;
    e_flag = 0; e_code = 0; e_idx = 0;
  endtask

  function automatic bit sfu_of(input logic a, input logic s, input logic [2:0] t);
    return a && s && t == 3'd2;
  endfunction

  function automatic bit res_of(input logic a, input logic s, input logic [2:0] t);
    return a && s && t >= 3'd1 && t <= 3'd5;
  endfunction

  task automatic model_step(input ins_t i);
    int c = 0;
    bit inbr  = (m_ip - m_br) < 3;
    bit insw  = (m_ip - m_sw) < 3;
    bit insfu = (m_ip - m_sfu) < 2;
    if (i.br) begin
      if (inbr)      c = 14;
      else if (insw) c = 15;
      m_br = m_ip; p_uni = 0; p_unia = 0; p_var = 0;
    end else begin
      int nsfu = sfu_of(i.add_act, i.add_spc, i.add_tgt) + sfu_of(i.mul_act, i.mul_spc, i.mul_tgt);
      int nres = res_of(i.add_act, i.add_spc, i.add_tgt) + res_of(i.mul_act, i.mul_spc, i.mul_tgt)
               + i.ld_tex + i.ld_tile + i.ld_tileu + i.ld_vmem;
      bit rfw  = (i.add_act && !i.add_spc) || (i.mul_act && !i.mul_spc) || (i.sig_wr && !i.sig_spc);
      bit mk   = i.thr_sw && (m_ip - m_sw == 1);
      bit endn = m_end || (i.thr_sw && m_mark);
      int swp  = (i.thr_sw && !mk) ? m_ip : m_sw;
      bit u    = i.ld_uni || i.ld_uni_rf;
      bit ua   = i.ld_unia || i.ld_unia_rf;
      if (p_var && (i.ld_uni || i.ld_unia))        c = 1;
      else if ((p_uni && ua) || (p_unia && u))     c = 2;
      else if (insw && nsfu > 0)                   c = 3;
      else if (insw && i.ld_var)                   c = 4;
      else if (insfu && i.rd_res)                  c = 5;
      else if (insfu && i.wr_res)                  c = 6;
      else if (insfu && nsfu > 0)                  c = 7;
      else if (nres > 1)                           c = 8;
      else if (i.thr_sw && inbr)                   c = 9;
      else if (mk && m_mark)                       c = 10;
      else if (i.thr_sw && !mk && insw)            c = 11;
      else if (endn && rfw)                        c = 12;
      else if (endn && i.add_twait && m_ip - swp == 2) c = 13;
      if (nsfu > 0) m_sfu = m_ip;
      if (i.thr_sw && m_mark) m_end = 1;
      if (mk) m_mark = 1;
      if (i.thr_sw && !mk) begin m_sw = m_ip; m_swc++; end
      p_uni = u; p_unia = ua; p_var = i.ld_var;
    end
    if (!e_flag && c != 0) begin e_flag = 1; e_code = c; e_idx = m_ip; end
    m_ip++;
  endtask

  task automatic model_eop();
    int c = 0;
    if (m_swc > 1 && !m_mark) c = 16;
    else if (!m_end)          c = 17;
    if (!e_flag && c != 0) begin e_flag = 1; e_code = c; e_idx = m_ip; end
  endtask

  task automatic check(input string req, input bit ef, input int ec, input int ei);
    n_chk++;
    if (err_flag !== ef || int'(err_code) != ec || int'(err_idx) != ei) begin
      n_bad++;
      $display("FAIL %s: flag/code/idx got %0d/%0d/%0d exp %0d/%0d/%0d",
               req, err_flag, err_code, err_idx, ef, ec, ei);
    end
  endtask

  // All drives happen at the falling edge
  task automatic do_reset(input bit single);
    @(negedge clk);
    vld = 0; eop = 0; cur = '0; cfg = single; rst = 1;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    model_reset(single);
  endtask

  task automatic send(input ins_t i);
    cur = i; vld = 1;
    model_step(i);
    @(negedge clk);
  endtask

  task automatic finish_prog();
    vld = 0; cur = '0; eop = 1;
    model_eop();
    @(negedge clk);
    eop = 0;
  endtask

  function automatic ins_t nop();
    return '0;
  endfunction

  function automatic ins_t sfu_ins();
    ins_t i = '0;
    i.add_act = 1; i.add_spc = 1; i.add_tgt = 3'd2;
    return i;
  endfunction

  function automatic ins_t br_ins();
    ins_t i = '0;
    i.br = 1;
    return i;
  endfunction

  function automatic ins_t sw_ins();
    ins_t i = '0;
    i.thr_sw = 1;
    return i;
  endfunction

  function automatic ins_t rnd_ins(input int dens);
    ins_t i = '0;
    i.br = ($urandom % 8) == 0;
    i.add_act = $urandom % 2; i.add_spc = ($urandom % 4) != 0; i.add_tgt = 3'($urandom % 6);
    i.mul_act = ($urandom % 3) == 0; i.mul_spc = ($urandom % 4) != 0; i.mul_tgt = 3'($urandom % 6);
    i.add_twait = ($urandom % dens) == 0;
    i.ld_var = ($urandom % dens) == 0; i.ld_uni = ($urandom % dens) == 0;
    i.ld_uni_rf = ($urandom % dens) == 0; i.ld_unia = ($urandom % dens) == 0;
    i.ld_unia_rf = ($urandom % dens) == 0; i.ld_tex = ($urandom % dens) == 0;
    i.ld_tile = ($urandom % dens) == 0; i.ld_tileu = ($urandom % dens) == 0;
    i.ld_vmem = ($urandom % dens) == 0; i.sig_wr = ($urandom % dens) == 0;
    i.sig_spc = $urandom % 2; i.thr_sw = ($urandom % 4) == 0;
    i.rd_res = ($urandom % dens) == 0; i.wr_res = ($urandom % dens) == 0;
    return i;
  endfunction

  task automatic report();
    if (!ended) begin
      ended = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, got 0 exp 1");
    report();
  end

  initial begin
    ins_t t;
    void'($urandom(32'd1234));

    // R1 reset state
    do_reset(0);
    check("R1", 0, 0, 0);
    n_chk++;
    if (eop_done !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: eop_done got %0d exp 0", eop_done);
    end

    // R3 result read after special-function start
    do_reset(0);
    send(sfu_ins());
    t = nop(); t.rd_res = 1; send(t);
    check("R3", 1, 5, 1);

    // R3 result read at distance 2 is legal
    do_reset(0);
    send(sfu_ins()); send(nop());
    t = nop(); t.rd_res = 1; send(t);
    check("R3", 0, 0, 0);

    // R2 branch at distance 2, and distance 3 boundary
    do_reset(0);
    send(br_ins()); send(nop()); send(br_ins());
    check("R2", 1, 14, 2);
    do_reset(0);
    send(br_ins()); send(nop()); send(nop()); send(br_ins());
    check("R2", 0, 0, 0);
    do_reset(0);
    send(br_ins()); send(sw_ins());
    check("R2", 1, 9, 1);

    // R4 varying load inside switch window
    do_reset(0);
    send(sw_ins());
    t = nop(); t.ld_var = 1; send(t);
    check("R4", 1, 4, 1);

    // R5 two shared resources
    do_reset(0);
    t = nop(); t.ld_tex = 1; t.ld_vmem = 1; send(t);
    check("R5", 1, 8, 0);

    // R6 uniform after varying, and address/plain mix
    do_reset(0);
    t = nop(); t.ld_var = 1; send(t);
    t = nop(); t.ld_uni = 1; send(t);
    check("R6", 1, 1, 1);
    do_reset(0);
    t = nop(); t.ld_unia = 1; send(t);
    t = nop(); t.ld_uni_rf = 1; send(t);
    check("R6", 1, 2, 1);

    // R7 second last-segment marker
    do_reset(0);
    send(sw_ins()); send(sw_ins()); send(nop()); send(nop()); send(nop());
    send(sw_ins()); send(sw_ins());
    check("R7", 1, 10, 6);

    // R8 register-file write after program end
    do_reset(0);
    send(sw_ins()); send(sw_ins()); send(nop()); send(nop()); send(sw_ins());
    t = nop(); t.add_act = 1; send(t);
    check("R8", 1, 12, 5);
    do_reset(0);
    send(sw_ins()); send(sw_ins()); send(nop()); send(nop()); send(sw_ins()); send(nop());
    t = nop(); t.add_twait = 1; send(t);
    check("R8", 1, 13, 6);

    // R9 clean program, missing marker, missing end
    do_reset(0);
    send(sw_ins()); send(sw_ins()); send(nop()); send(nop()); send(sw_ins());
    finish_prog();
    check("R9", 0, 0, 0);
    do_reset(0);
    send(sw_ins()); send(nop()); send(nop()); send(sw_ins());
    finish_prog();
    check("R9", 1, 16, 4);
    do_reset(0);
    finish_prog();
    check("R9", 1, 17, 0);

    // R10 single-segment mode
    do_reset(1);
    send(sw_ins());
    finish_prog();
    check("R10", 0, 0, 0);
    do_reset(1);
    send(sw_ins()); send(sw_ins());
    check("R10", 1, 10, 1);

    // R11 stickiness
    do_reset(0);
    send(br_ins()); send(br_ins());
    t = nop(); t.ld_tex = 1; t.ld_tile = 1; send(t);
    check("R11", 1, 14, 1);

    // R12 priority
    do_reset(0);
    t = nop(); t.ld_var = 1; send(t);
    t = nop(); t.ld_uni = 1; t.ld_tex = 1; t.ld_tile = 1; send(t);
    check("R12", 1, 1, 1);

    // R11/R12 random programs against the model
    for (int p = 0; p < 400; p++) begin
      int len = 3 + ($urandom % 12);
      int dens = (p % 2) ? 6 : 20;
      do_reset($urandom % 2);
      for (int k = 0; k < len; k++) begin
        send(rnd_ins(dens));
        check("R11", e_flag, e_code, e_idx);
      end
      finish_prog();
      check("R12", e_flag, e_code, e_idx);
    end

    report();
  end
endmodule